// File: doc/BRIEF.md
# Spur Calibration Controller

This block runs the digital side of a closed-loop spur-reduction pass for a frequency synthesizer with several charge-injection channels. One pulse on `start_i` starts a calibration. The controller handles the channels one after another, in ascending index. For each channel it steps the test pulse delay through every code and asks for one spur-power measurement per code. It then picks the delay where the power differs most from the sweep average. At that delay it finds the injection strength by successive approximation, working toward the lowest measured power.

Measurements come from outside through a one-cycle request pulse and a valid strobe that carries the measured value. During the pass, channels that are already calibrated hold their final codes. Channels that have not been reached yet stay disabled. At the end every channel is enabled with its final codes and `done_o` is raised. If a measurement never arrives, the pass stops and `err_o` is raised. The pass is meant to run only now and then, before normal operation.

Top module: `spur_cal_ctrl`

## Requirements
- R1: In idle, `start_i` high at a clock edge makes `busy_o` high from the next cycle and launches the first request. While busy, `start_i` has no effect: the pass continues with the same channel and delay sequence.
- R2: Each request is a one-cycle pulse on `meas_req_o`. `meas_valid_i` is taken only in the cycles after that pulse. Exactly one value of `meas_pwr_i` is consumed per request, and no new request is made while a value is awaited.
- R3: Channel sweep order. For the channel under test, the delay code steps through 0 to 2^DLY_W-1 in ascending order. The strength during the sweep is the most significant strength bit alone, and the channel is enabled.
- R4: Extremum choice. The sweep mean is floor(sum / 2^DLY_W). The chosen delay is the code with the largest |power - mean|. Ties go to the lowest code, so an all-equal sweep picks code 0.
- R5: Strength search at the chosen delay:
  - A reference is first measured with strength 0.
  - Each bit is then tried from the MSB down: the bit is set and one measurement is taken.
  - The bit is kept if the measured power is less than or equal to the reference, and that power becomes the new reference. Otherwise the bit is cleared.
- R6: While channel c is calibrated, channels below c are enabled with their final codes. Channels above c are disabled, with delay and strength 0.
- R7: Channels are calibrated in ascending index. A full pass makes exactly NUM_CH*(2^DLY_W+1+STR_W) requests.
- R8: `done_o` rises two cycles after the cycle that accepts the final valid. It stays high until the next start, with `busy_o` low and every channel enabled with its final codes. `done_o` and `err_o` are never high together.
- R9: Valid is accepted at any point in the TMO_CYC cycles that follow a request pulse. If it has not come by then, `err_o` is high in the next cycle. At the same time `busy_o` goes low and all channels are disabled with zero codes.
- R10: After reset, all outputs are 0.
- R11: A start clears `err_o` and `done_o` in the cycle in which `busy_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Starts a calibration pass when idle |
| meas_req_o | output | 1 | One-cycle request for a spur-power measurement |
| meas_valid_i | input | 1 | Strobe marking `meas_pwr_i` as the answer |
| meas_pwr_i | input | PWR_W | Measured total spur power |
| busy_o | output | 1 | Calibration pass in progress |
| done_o | output | 1 | Last pass completed |
| err_o | output | 1 | Last pass aborted by a measurement timeout |
| ch_en_o | output | NUM_CH | Per-channel injection enable |
| ch_dly_o | output | NUM_CH*DLY_W | Per-channel delay code, channel i at bits [i*DLY_W +: DLY_W] |
| ch_str_o | output | NUM_CH*STR_W | Per-channel strength code, channel i at bits [i*STR_W +: STR_W] |

## Verification
The trial delay and strength, and the enables of every channel, are valid in the same cycle as the request pulse. The bench compares them there against its own model of the search. It also checks that the request is low one cycle later. Values are answered after a latency of 1 to 3 cycles, and in one pass after exactly TMO_CYC cycles, the latest allowed. `done_o` is checked low one cycle and high two cycles after the final valid. In the timeout case `err_o` is checked low at the TMO_CYC-th cycle after the request and high one cycle later. All sampling is at the falling clock edge.

// File: rtl/spur_cal_pkg.sv
package spur_cal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MEAS,
    ST_SCAN,
    ST_COMMIT
  } cal_state_t;

  typedef enum logic [1:0] {
    PH_SWEEP,
    PH_BASE,
    PH_BIT
  } cal_phase_t;

endpackage

// File: rtl/spur_meas_port.sv
module spur_meas_port #(
  parameter int TMO_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic valid_i,
  output logic req_o,
  output logic got_o,
  output logic tmo_o
);
  localparam int TMO_W = $clog2(TMO_CYC + 1);
  localparam logic [TMO_W-1:0] CNT_LAST = TMO_W'(TMO_CYC - 1);

  logic             req_q, req_n;
  logic             wt_q, wt_n;
  logic [TMO_W-1:0] cnt_q, cnt_n;

  always_comb begin
    req_n = launch_i;
    wt_n  = wt_q;
    cnt_n = cnt_q;
    got_o = 1'b0;
    tmo_o = 1'b0;
    if (req_q) begin
      wt_n  = 1'b1;
      cnt_n = '0;
    end else if (wt_q) begin
      if (valid_i) begin
        got_o = 1'b1;
        wt_n  = 1'b0;
      end else if (cnt_q == CNT_LAST) begin
        tmo_o = 1'b1;
        wt_n  = 1'b0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      wt_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      req_q <= req_n;
      wt_q  <= wt_n;
      cnt_q <= cnt_n;
    end
  end

  assign req_o = req_q;

  assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  assert_no_req_in_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wt_q |-> !req_q);
  assert_tmo_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wt_q |-> (cnt_q <= CNT_LAST));

endmodule

// File: rtl/spur_peak_pick.sv
module spur_peak_pick #(
  parameter int PWR_W = 16,
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [DLY_W-1:0] wr_idx_i,
  input  logic [PWR_W-1:0] wr_pwr_i,
  input  logic             scan_i,
  input  logic [DLY_W-1:0] scan_idx_i,
  output logic [DLY_W-1:0] pick_idx_o
);
  localparam int NPTS  = 1 << DLY_W;
  localparam int SUM_W = PWR_W + DLY_W;

  logic [PWR_W-1:0] samp_q [NPTS];
  logic [PWR_W-1:0] samp_n [NPTS];
  logic [SUM_W-1:0] sum_q, sum_n;
  logic [PWR_W-1:0] best_dev_q, best_dev_n;
  logic [DLY_W-1:0] best_idx_q, best_idx_n;
  logic [PWR_W-1:0] mean, cur, dev, base_dev;
  logic [DLY_W-1:0] base_idx;
  logic             take;

  for (genvar g = 0; g < NPTS; g++) begin : g_samp
    localparam logic [DLY_W-1:0] SLOT = DLY_W'(g);
    always_comb samp_n[g] = (wr_i && (wr_idx_i == SLOT)) ? wr_pwr_i : samp_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) samp_q[g] <= '0;
      else        samp_q[g] <= samp_n[g];
    end
  end

  always_comb begin
    mean     = PWR_W'(sum_q >> DLY_W);
    cur      = samp_q[scan_idx_i];
    dev      = (cur >= mean) ? (cur - mean) : (mean - cur);
    base_dev = (scan_idx_i == '0) ? '0 : best_dev_q;
    base_idx = (scan_idx_i == '0) ? '0 : best_idx_q;
    take     = dev > base_dev;
    pick_idx_o = take ? scan_idx_i : base_idx;

    sum_n      = sum_q;
    best_dev_n = best_dev_q;
    best_idx_n = best_idx_q;
    if (clr_i)     sum_n = '0;
    else if (wr_i) sum_n = sum_q + SUM_W'(wr_pwr_i);
    if (scan_i) begin
      best_dev_n = take ? dev : base_dev;
      best_idx_n = pick_idx_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q      <= '0;
      best_dev_q <= '0;
      best_idx_q <= '0;
    end else begin
      sum_q      <= sum_n;
      best_dev_q <= best_dev_n;
      best_idx_q <= best_idx_n;
    end
  end

  assert_pick_not_ahead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_i |-> (pick_idx_o <= scan_idx_i));

endmodule

// File: rtl/spur_sar_step.sv
module spur_sar_step #(
  parameter int PWR_W = 16,
  parameter int STR_W = 4,
  parameter int BIT_W = 2
) (
  input  logic [STR_W-1:0] str_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic [PWR_W-1:0] pwr_i,
  input  logic [PWR_W-1:0] ref_i,
  output logic             keep_o,
  output logic [STR_W-1:0] kept_o,
  output logic [STR_W-1:0] trial_o
);
  logic [STR_W-1:0] mask_cur, mask_low;

  always_comb begin
    mask_cur = STR_W'(1) << bit_i;
    mask_low = (bit_i == '0) ? '0 : (STR_W'(1) << (bit_i - 1'b1));
    keep_o   = pwr_i <= ref_i;
    kept_o   = keep_o ? str_i : (str_i & ~mask_cur);
    trial_o  = kept_o | mask_low;
  end

endmodule

// File: rtl/spur_ch_drive.sv
module spur_ch_drive #(
  parameter int NUM_CH = 4,
  parameter int DLY_W  = 3,
  parameter int STR_W  = 4,
  parameter int CH_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     busy_i,
  input  logic                     done_i,
  input  logic [CH_W-1:0]          cur_ch_i,
  input  logic [DLY_W-1:0]         tr_dly_i,
  input  logic [STR_W-1:0]         tr_str_i,
  input  logic [NUM_CH*DLY_W-1:0]  fin_dly_i,
  input  logic [NUM_CH*STR_W-1:0]  fin_str_i,
  output logic [NUM_CH-1:0]        en_o,
  output logic [NUM_CH*DLY_W-1:0]  dly_o,
  output logic [NUM_CH*STR_W-1:0]  str_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [CH_W-1:0] IDX = CH_W'(i);
    always_comb begin
      en_o[i]                  = 1'b0;
      dly_o[i*DLY_W +: DLY_W]  = '0;
      str_o[i*STR_W +: STR_W]  = '0;
      if ((busy_i && (IDX < cur_ch_i)) || (!busy_i && done_i)) begin
        en_o[i]                 = 1'b1;
        dly_o[i*DLY_W +: DLY_W] = fin_dly_i[i*DLY_W +: DLY_W];
        str_o[i*STR_W +: STR_W] = fin_str_i[i*STR_W +: STR_W];
      end else if (busy_i && (IDX == cur_ch_i)) begin
        en_o[i]                 = 1'b1;
        dly_o[i*DLY_W +: DLY_W] = tr_dly_i;
        str_o[i*STR_W +: STR_W] = tr_str_i;
      end
    end
    if (i > 0) begin : g_chk
      assert_en_prefix_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en_o[i] |-> en_o[i-1]);
    end
  end

endmodule

// File: rtl/spur_cal_ctrl.sv
module spur_cal_ctrl
  import spur_cal_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DLY_W   = 3,
  parameter int STR_W   = 4,
  parameter int PWR_W   = 16,
  parameter int TMO_CYC = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  output logic                     meas_req_o,
  input  logic                     meas_valid_i,
  input  logic [PWR_W-1:0]         meas_pwr_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     err_o,
  output logic [NUM_CH-1:0]        ch_en_o,
  output logic [NUM_CH*DLY_W-1:0]  ch_dly_o,
  output logic [NUM_CH*STR_W-1:0]  ch_str_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int BIT_W = (STR_W > 1) ? $clog2(STR_W) : 1;
  localparam logic [DLY_W-1:0] DLY_LAST = '1;
  localparam logic [STR_W-1:0] STR_MID = STR_W'(1) << (STR_W - 1);
  localparam logic [CH_W-1:0]  CH_LAST = CH_W'(NUM_CH - 1);
  localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(STR_W - 1);

  logic rst_m_q, rst_s_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end
  assign rst_sync_n = rst_s_q;

  cal_state_t state_q, state_n;
  cal_phase_t phase_q, phase_n;
  logic [CH_W-1:0]         ch_q, ch_n;
  logic [DLY_W-1:0]        tr_dly_q, tr_dly_n;
  logic [STR_W-1:0]        tr_str_q, tr_str_n;
  logic [BIT_W-1:0]        bit_q, bit_n;
  logic [PWR_W-1:0]        ref_q, ref_n;
  logic [DLY_W-1:0]        scan_q, scan_n;
  logic                    done_q, done_n;
  logic                    err_q, err_n;
  logic [NUM_CH*DLY_W-1:0] fin_dly_q, fin_dly_n;
  logic [NUM_CH*STR_W-1:0] fin_str_q, fin_str_n;

  logic             launch, got, tmo, pk_clr, pk_wr, scan_en;
  logic [DLY_W-1:0] pick_idx;
  logic             keep;
  logic [STR_W-1:0] str_kept, str_trial;

  spur_meas_port #(.TMO_CYC(TMO_CYC)) u_port (
    .clk(clk), .rst_n(rst_sync_n), .launch_i(launch), .valid_i(meas_valid_i),
    .req_o(meas_req_o), .got_o(got), .tmo_o(tmo)
  );

  spur_peak_pick #(.PWR_W(PWR_W), .DLY_W(DLY_W)) u_peak (
    .clk(clk), .rst_n(rst_sync_n), .clr_i(pk_clr), .wr_i(pk_wr),
    .wr_idx_i(tr_dly_q), .wr_pwr_i(meas_pwr_i), .scan_i(scan_en),
    .scan_idx_i(scan_q), .pick_idx_o(pick_idx)
  );

  spur_sar_step #(.PWR_W(PWR_W), .STR_W(STR_W), .BIT_W(BIT_W)) u_sar (
    .str_i(tr_str_q), .bit_i(bit_q), .pwr_i(meas_pwr_i), .ref_i(ref_q),
    .keep_o(keep), .kept_o(str_kept), .trial_o(str_trial)
  );

  always_comb begin
    state_n   = state_q;
    phase_n   = phase_q;
    ch_n      = ch_q;
    tr_dly_n  = tr_dly_q;
    tr_str_n  = tr_str_q;
    bit_n     = bit_q;
    ref_n     = ref_q;
    scan_n    = scan_q;
    done_n    = done_q;
    err_n     = err_q;
    fin_dly_n = fin_dly_q;
    fin_str_n = fin_str_q;
    launch    = 1'b0;
    pk_clr    = 1'b0;
    pk_wr     = 1'b0;
    scan_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          done_n   = 1'b0;
          err_n    = 1'b0;
          ch_n     = '0;
          tr_dly_n = '0;
          tr_str_n = STR_MID;
          phase_n  = PH_SWEEP;
          pk_clr   = 1'b1;
          launch   = 1'b1;
          state_n  = ST_MEAS;
        end
      end
      ST_MEAS: begin
        if (tmo) begin
          err_n   = 1'b1;
          state_n = ST_IDLE;
        end else if (got) begin
          unique case (phase_q)
            PH_SWEEP: begin
              pk_wr = 1'b1;
              if (tr_dly_q == DLY_LAST) begin
                scan_n  = '0;
                state_n = ST_SCAN;
              end else begin
                tr_dly_n = tr_dly_q + 1'b1;
                launch   = 1'b1;
              end
            end
            PH_BASE: begin
              ref_n    = meas_pwr_i;
              bit_n    = BIT_TOP;
              tr_str_n = STR_MID;
              phase_n  = PH_BIT;
              launch   = 1'b1;
            end
            default: begin
              if (keep) ref_n = meas_pwr_i;
              if (bit_q == '0) begin
                tr_str_n = str_kept;
                state_n  = ST_COMMIT;
              end else begin
                tr_str_n = str_trial;
                bit_n    = bit_q - 1'b1;
                launch   = 1'b1;
              end
            end
          endcase
        end
      end
      ST_SCAN: begin
        scan_en = 1'b1;
        if (scan_q == DLY_LAST) begin
          tr_dly_n = pick_idx;
          tr_str_n = '0;
          phase_n  = PH_BASE;
          launch   = 1'b1;
          state_n  = ST_MEAS;
        end else begin
          scan_n = scan_q + 1'b1;
        end
      end
      default: begin
        fin_dly_n[ch_q*DLY_W +: DLY_W] = tr_dly_q;
        fin_str_n[ch_q*STR_W +: STR_W] = tr_str_q;
        if (ch_q == CH_LAST) begin
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end else begin
          ch_n     = ch_q + 1'b1;
          tr_dly_n = '0;
          tr_str_n = STR_MID;
          phase_n  = PH_SWEEP;
          pk_clr   = 1'b1;
          launch   = 1'b1;
          state_n  = ST_MEAS;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_SWEEP;
      ch_q      <= '0;
      tr_dly_q  <= '0;
      tr_str_q  <= '0;
      bit_q     <= '0;
      ref_q     <= '0;
      scan_q    <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      fin_dly_q <= '0;
      fin_str_q <= '0;
    end else begin
      state_q   <= state_n;
      phase_q   <= phase_n;
      ch_q      <= ch_n;
      tr_dly_q  <= tr_dly_n;
      tr_str_q  <= tr_str_n;
      bit_q     <= bit_n;
      ref_q     <= ref_n;
      scan_q    <= scan_n;
      done_q    <= done_n;
      err_q     <= err_n;
      fin_dly_q <= fin_dly_n;
      fin_str_q <= fin_str_n;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  spur_ch_drive #(.NUM_CH(NUM_CH), .DLY_W(DLY_W), .STR_W(STR_W), .CH_W(CH_W)) u_drive (
    .clk(clk), .rst_n(rst_sync_n), .busy_i(busy_o), .done_i(done_q),
    .cur_ch_i(ch_q), .tr_dly_i(tr_dly_q), .tr_str_i(tr_str_q),
    .fin_dly_i(fin_dly_q), .fin_str_i(fin_str_q),
    .en_o(ch_en_o), .dly_o(ch_dly_o), .str_o(ch_str_o)
  );

  assert_done_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(done_q && err_q));
  assert_busy_not_done_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_o |-> !done_q);
  assert_err_disables_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_q |-> (ch_en_o == '0));
  assert_scan_no_req_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_SCAN) |-> !meas_req_o);

endmodule

// File: tb/sim_spur_cal_ctrl.sv
module sim_spur_cal_ctrl;
  localparam int NUM_CH = 4;
  localparam int DLY_W  = 3;
  localparam int STR_W  = 4;
  localparam int PWR_W  = 16;
  localparam int TMO    = 16;
  localparam int NPTS   = 1 << DLY_W;
  localparam int MID    = 1 << (STR_W - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic meas_valid_i = 1'b0;
  logic [PWR_W-1:0] meas_pwr_i = '0;
  logic meas_req_o, busy_o, done_o, err_o;
  logic [NUM_CH-1:0] ch_en_o;
  logic [NUM_CH*DLY_W-1:0] ch_dly_o;
  logic [NUM_CH*STR_W-1:0] ch_str_o;

  int nchk = 0;
  int nerr = 0;
  int nreq = 0;
  bit abort = 0;
  int fin_d [NUM_CH];
  int fin_s [NUM_CH];

  always #5 clk = ~clk;

  spur_cal_ctrl #(.NUM_CH(NUM_CH), .DLY_W(DLY_W), .STR_W(STR_W), .PWR_W(PWR_W),
                  .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .meas_req_o(meas_req_o),
    .meas_valid_i(meas_valid_i), .meas_pwr_i(meas_pwr_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .ch_en_o(ch_en_o), .ch_dly_o(ch_dly_o),
    .ch_str_o(ch_str_o)
  );

  task automatic chk(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  function automatic int g_val(int seed, int ch, int d);
    case (seed)
      0: return 200 + ((d * 37 + ch * 53) % 29) * 7;
      1: return (d == 2) ? 140 : ((d == 5) ? 60 : 100);
      2: return 300;
      default: return 60000 + ((d * 13 + ch * 7) % 11) * 400;
    endcase
  endfunction

  function automatic int pw(int seed, int ch, int d, int s);
    int tgt = (ch * 5 + seed * 3 + 2) % 16;
    return g_val(seed, ch, d) + (s - tgt) * (s - tgt) * 3;
  endfunction

  task automatic serve(input int ch, input int d, input int s, input int p,
                       input int lat, input bit glitch, input string tag);
    logic [NUM_CH-1:0] ee;
    logic [NUM_CH*DLY_W-1:0] ed;
    logic [NUM_CH*STR_W-1:0] es;
    int w = 0;
    if (abort) return;
    while (meas_req_o !== 1'b1 && w < 300) begin
      @(negedge clk);
      w++;
    end
    if (meas_req_o !== 1'b1) begin
      chk(0, "R2 request missing", 0, 1);
      abort = 1;
      return;
    end
    nreq++;
    ee = '0; ed = '0; es = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (i < ch) begin
        ee[i] = 1'b1;
        ed[i*DLY_W +: DLY_W] = DLY_W'(fin_d[i]);
        es[i*STR_W +: STR_W] = STR_W'(fin_s[i]);
      end else if (i == ch) begin
        ee[i] = 1'b1;
        ed[i*DLY_W +: DLY_W] = DLY_W'(d);
        es[i*STR_W +: STR_W] = STR_W'(s);
      end
    end
    chk(ch_en_o == ee, {tag, " enables at request"}, 64'(ch_en_o), 64'(ee));
    chk(ch_dly_o == ed, {tag, " delays at request"}, 64'(ch_dly_o), 64'(ed));
    chk(ch_str_o == es, {tag, " strengths at request"}, 64'(ch_str_o), 64'(es));
    @(negedge clk);
    chk(meas_req_o == 1'b0, "R2 request lasts one cycle", 64'(meas_req_o), 0);
    if (glitch) begin
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R1 start while busy ignored", 64'(busy_o), 1);
      repeat (lat - 2) @(negedge clk);
    end else begin
      repeat (lat - 1) @(negedge clk);
    end
    meas_valid_i = 1'b1;
    meas_pwr_i = PWR_W'(p);
    @(negedge clk);
    meas_valid_i = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R1 busy after start", 64'(busy_o), 1);
    chk(done_o == 1'b0 && err_o == 1'b0, "R11 flags cleared by start",
        64'({done_o, err_o}), 0);
  endtask

  task automatic run_cal(input int seed, input int fix_lat, input bit glitch_on);
    int samp [NPTS];
    int sum, mean, best, bdev, dev, p, rf, cur, t, lat, r0;
    r0 = nreq;
    do_start();
    for (int ch = 0; ch < NUM_CH; ch++) begin
      sum = 0;
      for (int d = 0; d < NPTS; d++) begin
        p = pw(seed, ch, d, MID);
        samp[d] = p;
        sum += p;
        lat = (fix_lat > 0) ? fix_lat : 1 + (nreq % 3);
        if (glitch_on && ch == 1 && d == 1)
          serve(ch, d, MID, p, 3, 1'b1, "R3 R6 R7");
        else
          serve(ch, d, MID, p, lat, 1'b0, "R3 R6 R7");
      end
      mean = sum >> DLY_W;
      best = 0;
      bdev = 0;
      for (int d = 0; d < NPTS; d++) begin
        dev = (samp[d] >= mean) ? samp[d] - mean : mean - samp[d];
        if (dev > bdev) begin
          bdev = dev;
          best = d;
        end
      end
      rf = pw(seed, ch, best, 0);
      lat = (fix_lat > 0) ? fix_lat : 1 + (nreq % 3);
      serve(ch, best, 0, rf, lat, 1'b0, "R4 R6");
      cur = 0;
      for (int b = STR_W - 1; b >= 0; b--) begin
        t = cur | (1 << b);
        p = pw(seed, ch, best, t);
        lat = (fix_lat > 0) ? fix_lat : 1 + (nreq % 3);
        serve(ch, best, t, p, lat, 1'b0, "R5 R6");
        if (p <= rf) begin
          cur = t;
          rf = p;
        end
      end
      fin_d[ch] = best;
      fin_s[ch] = cur;
    end
    if (abort) return;
    chk(done_o == 1'b0, "R8 done not early", 64'(done_o), 0);
    @(negedge clk);
    chk(done_o == 1'b1 && busy_o == 1'b0, "R8 done two cycles after last valid",
        64'({done_o, busy_o}), 64'b10);
    chk(nreq - r0 == NUM_CH * (NPTS + 1 + STR_W), "R7 request count",
        64'(nreq - r0), 64'(NUM_CH * (NPTS + 1 + STR_W)));
    repeat (3) @(negedge clk);
    for (int i = 0; i < NUM_CH; i++) begin
      chk(ch_en_o[i] == 1'b1, "R8 channel enabled after done", 64'(ch_en_o[i]), 1);
      chk(ch_dly_o[i*DLY_W +: DLY_W] == DLY_W'(fin_d[i]), "R8 R4 final delay",
          64'(ch_dly_o[i*DLY_W +: DLY_W]), 64'(fin_d[i]));
      chk(ch_str_o[i*STR_W +: STR_W] == STR_W'(fin_s[i]), "R8 R5 final strength",
          64'(ch_str_o[i*STR_W +: STR_W]), 64'(fin_s[i]));
    end
    chk(done_o == 1'b1 && err_o == 1'b0, "R8 done held", 64'({done_o, err_o}), 64'b10);
  endtask

  task automatic run_timeout();
    int w = 0;
    do_start();
    for (int d = 0; d < 3; d++)
      serve(0, d, MID, pw(0, 0, d, MID), 2, 1'b0, "R3 R6");
    while (meas_req_o !== 1'b1 && w < 300) begin
      @(negedge clk);
      w++;
    end
    chk(meas_req_o == 1'b1, "R9 request before timeout", 64'(meas_req_o), 1);
    repeat (TMO) @(negedge clk);
    chk(err_o == 1'b0 && busy_o == 1'b1, "R9 no early timeout",
        64'({err_o, busy_o}), 64'b01);
    @(negedge clk);
    chk(err_o == 1'b1 && busy_o == 1'b0 && done_o == 1'b0, "R9 timeout flags",
        64'({err_o, busy_o, done_o}), 64'b100);
    chk(ch_en_o == '0 && ch_dly_o == '0 && ch_str_o == '0, "R9 channels cleared",
        64'(ch_en_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(meas_req_o == 0 && busy_o == 0 && done_o == 0 && err_o == 0, "R10 reset flags",
        64'({meas_req_o, busy_o, done_o, err_o}), 0);
    chk(ch_en_o == '0 && ch_dly_o == '0 && ch_str_o == '0, "R10 reset channels",
        64'({ch_en_o, ch_dly_o, ch_str_o}), 0);
    run_cal(0, 0, 1'b1);
    run_cal(1, 0, 1'b0);
    run_cal(2, 0, 1'b0);
    run_timeout();
    run_cal(3, TMO, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule